// File: doc/BRIEF.md
# Packed Palette RAM Write Port

This block holds a 256-entry colour lookup table, 8 bits per red, green and blue channel. A narrow register interface loads it: software first writes an entry index, then streams 32-bit data words. Each word carries four channel bytes taken from a continuous red, green, blue byte stream. Three consecutive words therefore fill four palette entries, and a word boundary usually falls inside an entry.

An internal byte pointer starts at three times the written index. It advances by four bytes on every data word. An entry is written to storage only when its blue byte arrives, so a partly sent entry never shows mixed old and new channels. A separate read port serves a display pipeline: it turns an 8-bit pixel index into a 24-bit RGB value one clock later.

Top module: `clut_pack_port`

## Requirements
- R1: After an active-high synchronous reset, the byte pointer is 0. Data words sent with no index write fill entries from entry 0.
- R2: A write with `wr_sel` = 0 (index port) sets the pointer to channel red of entry `wr_data[7:0]`.
- R3: A write with `wr_sel` = 1 (data port) consumes four bytes, most significant byte first. These bytes follow the stream r,g,b,r,g,b… from the pointer. Three words after an index write of N fill entries N to N+3.
- R4: An entry changes only in the cycle its blue byte is consumed. Until then, an entry whose red or green bytes were already sent keeps its previous value.
- R5: Successive data words keep advancing the pointer by four bytes, across any number of groups of four entries.
- R6: The byte stream wraps from the blue byte of entry 255 to the red byte of entry 0.
- R7: An index write in the middle of a group restarts the pointer at the new entry. The entry left half sent keeps its old value.
- R8: Writes with `wr_sel` = 2 (control) or 3 (cursor) have no effect on the pointer or the table. Any cycle with `wr_en` low also has no effect.
- R9: `rd_rgb` shows `{red, green, blue}` of the entry at `rd_idx` one clock after `rd_idx` is presented. A read in the same cycle as a commit to that entry returns the value before the commit.
- R10: Reset leaves the palette contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 index, 1 data, 2 control, 3 cursor |
| wr_data | input | 32 | Write data |
| rd_idx | input | 8 | Pixel index for lookup |
| rd_rgb | output | 24 | Looked-up colour, red in bits 23:16, blue in 7:0 |

## Verification
The assertions assume two things about the inputs: `wr_sel` and `wr_data` are known whenever `wr_en` is high, and reset is held for at least one clock before the first write. The stimulus drives every input on the falling edge with defined values. It raises `wr_en` only inside write tasks, which first set the select and data.

The bench checks some effects that the pointer assertions cannot see, such as commit timing and wrap-around. It does this by sweeping the whole table from several start indices, including one that wraps. It then reads back every entry and compares it against a byte-stream model kept in the bench.

// File: rtl/clut_pkg.sv
package clut_pkg;

  typedef enum logic [1:0] {
    PORT_INDEX  = 2'd0,
    PORT_DATA   = 2'd1,
    PORT_CTRL   = 2'd2,
    PORT_CURSOR = 2'd3
  } port_sel_e;

  localparam logic [1:0] CH_R = 2'd0;
  localparam logic [1:0] CH_G = 2'd1;
  localparam logic [1:0] CH_B = 2'd2;

  // channel that follows c in the r,g,b byte stream
  function automatic logic [1:0] chan_next(input logic [1:0] c);
    return (c == CH_B) ? CH_R : c + 2'd1;
  endfunction

  // true when the byte at channel c completes an entry
  function automatic logic chan_closes(input logic [1:0] c);
    return c == CH_B;
  endfunction

endpackage

// File: rtl/clut_ptr.sv
module clut_ptr
  import clut_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic             adv,
  input  logic [IDX_W-1:0] nxt_ent,
  input  logic [1:0]       nxt_ch,
  input  logic [CH_W-1:0]  nxt_r,
  input  logic [CH_W-1:0]  nxt_g,
  output logic [IDX_W-1:0] ent,
  output logic [1:0]       ch,
  output logic [CH_W-1:0]  stg_r,
  output logic [CH_W-1:0]  stg_g
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ent   <= '0;
      ch    <= CH_R;
      stg_r <= '0;
      stg_g <= '0;
    end else if (ld) begin
      ent <= ld_idx;
      ch  <= CH_R;
    end else if (adv) begin
      ent   <= nxt_ent;
      ch    <= nxt_ch;
      stg_r <= nxt_r;
      stg_g <= nxt_g;
    end
  end

endmodule

// File: rtl/clut_unpack.sv
module clut_unpack
  import clut_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8,
  parameter int LANES = 4
) (
  input  logic                              act,
  input  logic [IDX_W-1:0]                  ent_i,
  input  logic [1:0]                        ch_i,
  input  logic [LANES*CH_W-1:0]             word_i,
  input  logic [CH_W-1:0]                   sr_i,
  input  logic [CH_W-1:0]                   sg_i,
  output logic [LANES-1:0]                  we_o,
  output logic [LANES-1:0][IDX_W-1:0]       ent_o,
  output logic [LANES-1:0][3*CH_W-1:0]      rgb_o,
  output logic [IDX_W-1:0]                  ent_end,
  output logic [1:0]                        ch_end,
  output logic [CH_W-1:0]                   sr_o,
  output logic [CH_W-1:0]                   sg_o
);

  localparam int WORD_W = LANES * CH_W;
  localparam logic [IDX_W-1:0] ENT_ONE = IDX_W'(1);

  logic [IDX_W-1:0] pe  [LANES+1];
  logic [1:0]       pc  [LANES+1];
  logic [CH_W-1:0]  r_c [LANES+1];
  logic [CH_W-1:0]  g_c [LANES+1];

  assign pe[0]  = ent_i;
  assign pc[0]  = ch_i;
  assign r_c[0] = sr_i;
  assign g_c[0] = sg_i;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [CH_W-1:0] lane_b;
    // most significant byte is first in stream order
    assign lane_b     = word_i[WORD_W-1-k*CH_W -: CH_W];
    assign we_o[k]    = act && chan_closes(pc[k]);
    assign ent_o[k]   = pe[k];
    assign rgb_o[k]   = {r_c[k], g_c[k], lane_b};
    assign r_c[k+1]   = (pc[k] == CH_R) ? lane_b : r_c[k];
    assign g_c[k+1]   = (pc[k] == CH_G) ? lane_b : g_c[k];
    assign pc[k+1]    = chan_next(pc[k]);
    assign pe[k+1]    = chan_closes(pc[k]) ? pe[k] + ENT_ONE : pe[k];
  end

  assign ent_end = pe[LANES];
  assign ch_end  = pc[LANES];
  assign sr_o    = r_c[LANES];
  assign sg_o    = g_c[LANES];

endmodule

// File: rtl/clut_store.sv
module clut_store #(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8,
  parameter int LANES = 4
) (
  input  logic                         clk,
  input  logic [LANES-1:0]             we,
  input  logic [LANES-1:0][IDX_W-1:0]  wid,
  input  logic [LANES-1:0][3*CH_W-1:0] wdat,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [3*CH_W-1:0]            rd_rgb
);

  localparam int NENT  = 1 << IDX_W;
  localparam int RGB_W = 3 * CH_W;

  logic [RGB_W-1:0] mem [NENT];

  // lanes of one word never close the same entry
  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (we[k]) mem[wid[k]] <= wdat[k];
    end
    rd_rgb <= mem[rd_idx];
  end

endmodule

// File: rtl/clut_pack_port.sv
module clut_pack_port
  import clut_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8,
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [LANES*CH_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [3*CH_W-1:0]       rd_rgb
);

  localparam int RGB_W = 3 * CH_W;

  logic                         idx_wr, dat_wr;
  logic [IDX_W-1:0]             ptr_ent, nxt_ent;
  logic [1:0]                   ptr_ch, nxt_ch;
  logic [CH_W-1:0]              stg_r, stg_g, nxt_r, nxt_g;
  logic [LANES-1:0]             commit;
  logic [LANES-1:0][IDX_W-1:0]  commit_ent;
  logic [LANES-1:0][RGB_W-1:0]  commit_rgb;

  assign idx_wr = wr_en && (wr_sel == PORT_INDEX);
  assign dat_wr = wr_en && (wr_sel == PORT_DATA);

  clut_ptr #(.IDX_W(IDX_W), .CH_W(CH_W)) u_ptr (
    .clk(clk), .rst(rst),
    .ld(idx_wr), .ld_idx(wr_data[IDX_W-1:0]),
    .adv(dat_wr), .nxt_ent(nxt_ent), .nxt_ch(nxt_ch),
    .nxt_r(nxt_r), .nxt_g(nxt_g),
    .ent(ptr_ent), .ch(ptr_ch), .stg_r(stg_r), .stg_g(stg_g)
  );

  clut_unpack #(.IDX_W(IDX_W), .CH_W(CH_W), .LANES(LANES)) u_unpack (
    .act(dat_wr), .ent_i(ptr_ent), .ch_i(ptr_ch), .word_i(wr_data),
    .sr_i(stg_r), .sg_i(stg_g),
    .we_o(commit), .ent_o(commit_ent), .rgb_o(commit_rgb),
    .ent_end(nxt_ent), .ch_end(nxt_ch), .sr_o(nxt_r), .sg_o(nxt_g)
  );

  clut_store #(.IDX_W(IDX_W), .CH_W(CH_W), .LANES(LANES)) u_store (
    .clk(clk), .we(commit), .wid(commit_ent), .wdat(commit_rgb),
    .rd_idx(rd_idx), .rd_rgb(rd_rgb)
  );

endmodule

// File: rtl/clut_pack_chk.sv
module clut_pack_chk #(
  parameter int IDX_W = 8,
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [7:0]       wr_lo,
  input logic [IDX_W-1:0] ptr_ent,
  input logic [1:0]       ptr_ch,
  input logic [LANES-1:0] commit
);

  localparam int NBYTES = 3 * (1 << IDX_W);

  int unsigned bpos;
  int unsigned bnext;
  assign bpos  = 3 * int'(ptr_ent) + int'(ptr_ch);
  assign bnext = (bpos + LANES) % NBYTES;

  // R1: reset returns the stream to byte 0
  a_r1_reset_ptr: assert property (@(posedge clk)
    rst |=> (bpos == 0));

  // R2: index write lands on red of the given entry
  a_r2_index_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0) |=> (bpos == 3 * int'($past(wr_lo[IDX_W-1:0]))));

  // R5 / R6: data write moves LANES bytes, modulo the table size
  a_r5_advance: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd1) |=> (bpos == $past(bnext)));

  // R8: control, cursor and idle cycles hold the pointer
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || wr_sel[1]) |=> $stable(bpos));

  // R4: commits only on data writes, two when the word starts on blue
  a_r4_commit_count: assert property (@(posedge clk) disable iff (rst)
    $countones(commit) == ((wr_en && wr_sel == 2'd1) ? ((ptr_ch == 2'd2) ? 2 : 1) : 0));

endmodule

bind clut_pack_port clut_pack_chk #(.IDX_W(IDX_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_lo(wr_data[7:0]), .ptr_ent(ptr_ent), .ptr_ch(ptr_ch), .commit(commit)
);

// File: tb/sim_clut_pack_port.sv
module sim_clut_pack_port;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_idx = '0;
  logic [23:0] rd_rgb;

  int errors = 0;
  int checks = 0;

  logic [23:0] exp_pal [256];
  logic [7:0]  sb [768];
  int          bp = 0;

  always #2 clk = ~clk;

  clut_pack_port u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_rgb(rd_rgb)
  );

  function automatic logic [31:0] pat(input int i, input logic [31:0] s);
    return (32'(i) * 32'h9E3779B1) ^ s;
  endfunction

  // model: flat byte stream, entry closes at every third byte
  task automatic model_word(input logic [31:0] w);
    for (int k = 0; k < 4; k++) begin
      sb[bp] = w[31-8*k -: 8];
      if (bp % 3 == 2) exp_pal[bp/3] = {sb[bp-2], sb[bp-1], sb[bp]};
      bp = (bp + 1) % 768;
    end
  endtask

  task automatic send(input logic [1:0] sel, input logic [31:0] d, input bit en);
    wr_en = en; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (en && sel == 2'd0) bp = 3 * int'(d[7:0]);
    if (en && sel == 2'd1) model_word(d);
  endtask

  task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic look(input int idx, input string tag);
    rd_idx = idx[7:0];
    @(negedge clk);
    chk($sformatf("%s entry %0d", tag, idx), rd_rgb, exp_pal[idx]);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    bp = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all) got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] old_v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    bp = 0;

    // R1: data words from reset start at entry 0
    for (int i = 0; i < 3; i++) send(2'd1, pat(i, 32'h1234_5678), 1'b1);
    for (int e = 0; e < 4; e++) look(e, "R1 reset pointer");

    // R3 R5: full fill from entry 0, then full read sweep (R9 latency)
    send(2'd0, 32'd0, 1'b1);
    for (int i = 0; i < 192; i++) send(2'd1, pat(i, 32'hA5C3_0F1E), 1'b1);
    for (int e = 0; e < 256; e++) look(e, "R3 R5 R9 fill from 0");

    // R6 R5: full fill starting at 128, wrapping through entry 255
    send(2'd0, 32'd128, 1'b1);
    for (int i = 0; i < 192; i++) send(2'd1, pat(i + 7, 32'h3C96_E187), 1'b1);
    for (int e = 0; e < 256; e++) look(e, "R6 R5 fill from 128");

    // R4: commit per word, partly sent entries keep old values
    send(2'd0, 32'd8, 1'b1);
    send(2'd1, 32'h1122_3344, 1'b1);
    look(8, "R4 word0 closes");
    look(9, "R4 word0 partial");
    send(2'd1, 32'h5566_7788, 1'b1);
    look(9, "R4 word1 closes");
    look(10, "R4 word1 partial");
    send(2'd1, 32'h99AA_BBCC, 1'b1);
    look(10, "R4 word2 first");
    look(11, "R4 word2 second");

    // R7: index write mid-group
    send(2'd0, 32'd20, 1'b1);
    send(2'd1, 32'hDEAD_BEEF, 1'b1);
    send(2'd0, 32'd40, 1'b1);
    for (int i = 0; i < 3; i++) send(2'd1, pat(i, 32'h0BAD_F00D), 1'b1);
    look(20, "R7 closed before restart");
    look(21, "R7 abandoned entry");
    for (int e = 40; e < 44; e++) look(e, "R7 restart target");

    // R6: wrap from entry 255 blue to entry 0 red
    send(2'd0, 32'd252, 1'b1);
    for (int i = 0; i < 4; i++) send(2'd1, pat(i, 32'h7777_1111), 1'b1);
    for (int e = 252; e < 256; e++) look(e, "R6 tail");
    look(0, "R6 wrapped entry");
    look(1, "R6 wrapped partial");

    // R8: control, cursor and idle writes ignored
    send(2'd0, 32'd60, 1'b1);
    send(2'd2, 32'hFFFF_FFFF, 1'b1);
    send(2'd3, 32'h0000_0000, 1'b1);
    send(2'd1, 32'hFEED_FACE, 1'b0);
    send(2'd0, 32'd99, 1'b0);
    for (int e = 56; e < 64; e++) look(e, "R8 no table change");
    for (int i = 0; i < 3; i++) send(2'd1, pat(i, 32'h2468_ACE0), 1'b1);
    for (int e = 60; e < 64; e++) look(e, "R8 pointer kept");
    look(99, "R8 idle index ignored");

    // R9: read colliding with commit returns the old value
    send(2'd0, 32'd4, 1'b1);
    old_v = exp_pal[4];
    rd_idx = 8'd4;
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'h0102_0304;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 same-cycle read entry 4", rd_rgb, old_v);
    model_word(32'h0102_0304);
    @(negedge clk);
    chk("R9 next-cycle read entry 4", rd_rgb, exp_pal[4]);

    // R10: reset keeps the table
    do_reset();
    for (int e = 0; e < 256; e++) look(e, "R10 table after reset");

    // R1: pointer back at entry 0 after reset, mid-group before
    send(2'd1, 32'hC0FF_EE00, 1'b1);
    do_reset();
    for (int i = 0; i < 3; i++) send(2'd1, pat(i, 32'h5A5A_0000), 1'b1);
    for (int e = 0; e < 5; e++) look(e, "R1 after second reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule